// File: doc/BRIEF.md
# Single-Cycle Eight-Register Processor Datapath

This block is a single-cycle processor for a six-operation instruction set. In every enabled cycle it fetches one 25-bit word from its instruction store and splits it into fields. The 3-bit opcode goes through a one-hot decoder that picks a row of a constant control table. That row sets the register-file write enable, the write-data and write-address selects, the ALU function and operand select, the data-memory write enable and the next-PC source. The operations are register add, bitwise NAND, load and store with a signed offset, branch-if-equal, and jump-and-link through a register. Two spare opcodes give a halt and a no-op.

The instruction and data stores live inside the top level. While `run_i` is low, a loader port writes them and the core state does not change. A peek port reads any register and any data word, so a test harness can load a program and then inspect the architectural state. The jump-and-link operation writes the return address (PC+1) into one register and, in the same cycle, takes the new PC from another register. When both fields name the same register, the jump uses the value read before the write, and the register ends up holding PC+1.

Top module: `sc_proc`

## Requirements
- R1: While rst_ni is low, the PC and all eight 32-bit registers are cleared to zero, and pc_o reads zero.
- R2: Opcode 000 (add) writes R[a]+R[b] (mod 2^32) into the register named by bits [2:0], where a is bits [21:19] and b is bits [18:16]. The PC advances by one.
- R3: Opcode 001 (nand) writes ~(R[a] & R[b]) into the register named by bits [2:0]. The PC advances by one.
- R4: Opcode 010 (load) forms the address R[a] + sign-extended bits [15:0]. It loads the data word at the low log2(DMEM_DEPTH) bits of that address into R[b]. The PC advances by one.
- R5: Opcode 011 (store) writes R[b] to the data word at the same address. It leaves every register unchanged, and the PC advances by one.
- R6: Opcode 100 (branch-if-equal) sets the PC to PC+1+sext(offset) when R[a]==R[b] and to PC+1 otherwise. It writes neither registers nor memory.
- R7: Opcode 101 (jump-and-link) writes PC+1 into R[b] and loads the old value of R[a] into the PC. When a==b, the jump target is the value before the write.
- R8: Opcode 110 (halt) raises halt_o. It holds the PC and writes nothing.
- R9: Opcode 111 (no-op) only advances the PC by one.
- R10: While run_i is low, no register or PC changes. The loader ports write the instruction store and the data store, and the PC indexes the instruction store modulo IMEM_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Execute one instruction per cycle when high |
| imem_ld_we_i | input | 1 | Instruction-store load strobe (honoured while run_i is low) |
| imem_ld_addr_i | input | clog2(IMEM_DEPTH) | Instruction-store load address |
| imem_ld_data_i | input | 25 | Instruction word to load |
| dmem_ld_we_i | input | 1 | Data-store load strobe (honoured while run_i is low) |
| dmem_ld_addr_i | input | clog2(DMEM_DEPTH) | Data-store load address |
| dmem_ld_data_i | input | 32 | Data word to load |
| peek_reg_sel_i | input | 3 | Register to observe |
| peek_reg_o | output | 32 | Value of the selected register |
| peek_mem_addr_i | input | clog2(DMEM_DEPTH) | Data word to observe |
| peek_mem_o | output | 32 | Value of the selected data word |
| pc_o | output | 32 | Current program counter |
| halt_o | output | 1 | Current instruction is halt |

## Verification
The assertions assume two things. The loader strobes are used only while run_i is low. The fetched instruction word is defined in every cycle with run_i high, so each opcode-based check applies to a real instruction. The bench keeps to this: it writes the instruction store only with run_i low, always writes the word at the current PC before it raises run_i for one cycle, and loads data only before execution starts. Register contents are therefore always known to the bench's own instruction-level model. That model supplies the expected register, PC and memory values after every step.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN    = 32;
  localparam int ILEN    = 25;
  localparam int NREG    = 8;
  localparam int RAW     = $clog2(NREG);
  localparam int OPW     = 3;
  localparam int NOPS    = 1 << OPW;
  localparam int OFFW    = 16;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 3'b000,
    OP_NAND = 3'b001,
    OP_LW   = 3'b010,
    OP_SW   = 3'b011,
    OP_BEQ  = 3'b100,
    OP_JALR = 3'b101,
    OP_HALT = 3'b110,
    OP_NOP  = 3'b111
  } op_e;

  localparam logic [1:0] WSEL_ALU = 2'd0;
  localparam logic [1:0] WSEL_MEM = 2'd1;
  localparam logic [1:0] WSEL_PC1 = 2'd2;

  typedef struct packed {
    logic       rf_we;
    logic [1:0] wsel;
    logic       dst_rd;   // 1: dest field, 0: regB field
    logic       alu_nand;
    logic       alu_imm;
    logic       dmem_we;
    logic       branch;
    logic       jump;
    logic       halt;
  } ctrl_t;

  function automatic ctrl_t ctrl_row(input logic [OPW-1:0] op);
    ctrl_t r;
    r = '0;
    case (op_e'(op))
      OP_ADD:  begin r.rf_we = 1'b1; r.wsel = WSEL_ALU; r.dst_rd = 1'b1; end
      OP_NAND: begin r.rf_we = 1'b1; r.wsel = WSEL_ALU; r.dst_rd = 1'b1; r.alu_nand = 1'b1; end
      OP_LW:   begin r.rf_we = 1'b1; r.wsel = WSEL_MEM; r.alu_imm = 1'b1; end
      OP_SW:   begin r.dmem_we = 1'b1; r.alu_imm = 1'b1; end
      OP_BEQ:  r.branch = 1'b1;
      OP_JALR: begin r.rf_we = 1'b1; r.wsel = WSEL_PC1; r.jump = 1'b1; end
      OP_HALT: r.halt = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [OPW-1:0] opc_i,
  output ctrl_t          ctrl_o
);
  logic [NOPS-1:0] onehot;
  ctrl_t           rows [NOPS];

  for (genvar g = 0; g < NOPS; g++) begin : g_row
    localparam ctrl_t ROM_ROW = ctrl_row(OPW'(g));
    assign onehot[g] = (opc_i == OPW'(g));
    assign rows[g]   = onehot[g] ? ROM_ROW : '0;
  end

  always_comb begin
    ctrl_o = '0;
    for (int i = 0; i < NOPS; i++) ctrl_o = ctrl_t'(ctrl_o | rows[i]);
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_i,
  input  logic [RAW-1:0]  rb_i,
  input  logic [RAW-1:0]  rp_i,
  output logic [XLEN-1:0] ra_o,
  output logic [XLEN-1:0] rb_o,
  output logic [XLEN-1:0] rp_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign ra_o = regs_q[ra_i];
  assign rb_o = regs_q[rb_i];
  assign rp_o = regs_q[rp_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_reg_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            use_imm_i,
  input  logic            nand_i,
  output logic [XLEN-1:0] res_o,
  output logic            eq_o
);
  logic [XLEN-1:0] b;
  assign b     = use_imm_i ? imm_i : b_reg_i;
  assign res_o = nand_i ? ~(a_i & b) : (a_i + b);
  assign eq_o  = (a_i == b_reg_i);
endmodule

// File: rtl/sc_pc_next.sv
module sc_pc_next
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] off_i,
  input  logic [XLEN-1:0] target_i,
  input  logic            eq_i,
  input  logic            branch_i,
  input  logic            jump_i,
  input  logic            halt_i,
  output logic [XLEN-1:0] pc1_o,
  output logic [XLEN-1:0] next_o
);
  assign pc1_o = pc_i + XLEN'(1);

  always_comb begin
    if (jump_i)               next_o = target_i;
    else if (branch_i && eq_i) next_o = pc1_o + off_i;
    else if (halt_i)          next_o = pc_i;
    else                      next_o = pc1_o;
  end
endmodule

// File: rtl/sc_proc.sv
module sc_proc
  import sc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic                          imem_ld_we_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_ld_addr_i,
  input  logic [24:0]                   imem_ld_data_i,
  input  logic                          dmem_ld_we_i,
  input  logic [$clog2(DMEM_DEPTH)-1:0] dmem_ld_addr_i,
  input  logic [31:0]                   dmem_ld_data_i,
  input  logic [2:0]                    peek_reg_sel_i,
  output logic [31:0]                   peek_reg_o,
  input  logic [$clog2(DMEM_DEPTH)-1:0] peek_mem_addr_i,
  output logic [31:0]                   peek_mem_o,
  output logic [31:0]                   pc_o,
  output logic                          halt_o
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);

  logic [ILEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];

  logic [XLEN-1:0] pc_q, pc_next, pc1;
  logic [ILEN-1:0] instr;
  logic [OPW-1:0]  opc;
  logic [RAW-1:0]  fld_a, fld_b, fld_d, waddr;
  logic [XLEN-1:0] off_ext, rd_a, rd_b, alu_res, mem_rd, wdata;
  logic            alu_eq, rf_we, dmem_we;
  ctrl_t           ctrl;

  // fetch and field split
  assign instr   = imem[pc_q[IAW-1:0]];
  assign opc     = instr[24:22];
  assign fld_a   = instr[21:19];
  assign fld_b   = instr[18:16];
  assign fld_d   = instr[2:0];
  assign off_ext = {{(XLEN-OFFW){instr[OFFW-1]}}, instr[OFFW-1:0]};

  sc_decoder u_dec (
    .opc_i  (opc),
    .ctrl_o (ctrl)
  );

  assign rf_we   = run_i & ctrl.rf_we;
  assign dmem_we = run_i & ctrl.dmem_we;
  assign waddr   = ctrl.dst_rd ? fld_d : fld_b;

  always_comb begin
    case (ctrl.wsel)
      WSEL_MEM: wdata = mem_rd;
      WSEL_PC1: wdata = pc1;
      default:  wdata = alu_res;
    endcase
  end

  sc_regfile u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (fld_a),
    .rb_i   (fld_b),
    .rp_i   (peek_reg_sel_i),
    .ra_o   (rd_a),
    .rb_o   (rd_b),
    .rp_o   (peek_reg_o),
    .we_i   (rf_we),
    .wa_i   (waddr),
    .wd_i   (wdata)
  );

  sc_alu u_alu (
    .a_i       (rd_a),
    .b_reg_i   (rd_b),
    .imm_i     (off_ext),
    .use_imm_i (ctrl.alu_imm),
    .nand_i    (ctrl.alu_nand),
    .res_o     (alu_res),
    .eq_o      (alu_eq)
  );

  // jalr target is the pre-write read of regA, so a==b is safe
  sc_pc_next u_pcn (
    .pc_i     (pc_q),
    .off_i    (off_ext),
    .target_i (rd_a),
    .eq_i     (alu_eq),
    .branch_i (ctrl.branch),
    .jump_i   (ctrl.jump),
    .halt_i   (ctrl.halt),
    .pc1_o    (pc1),
    .next_o   (pc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (run_i) pc_q <= pc_next;
  end

  assign mem_rd = dmem[alu_res[DAW-1:0]];

  always_ff @(posedge clk_i) begin
    if (dmem_we)                      dmem[alu_res[DAW-1:0]] <= rd_b;
    else if (!run_i && dmem_ld_we_i)  dmem[dmem_ld_addr_i]   <= dmem_ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (!run_i && imem_ld_we_i) imem[imem_ld_addr_i] <= imem_ld_data_i;
  end

  assign peek_mem_o = dmem[peek_mem_addr_i];
  assign pc_o       = pc_q;
  assign halt_o     = ctrl.halt;
endmodule

// File: rtl/sc_proc_chk.sv
module sc_proc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_i,
  input logic [2:0]  opc,
  input logic [31:0] pc_q,
  input logic [31:0] rd_a,
  input logic [31:0] off_ext,
  input logic        alu_eq,
  input logic        rf_we,
  input logic        dmem_we
);
  assert_halt_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && opc == 3'b110) |=> (pc_q == $past(pc_q)));

  assert_jalr_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && opc == 3'b101) |=> (pc_q == $past(rd_a)));

  assert_nop_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && opc == 3'b111) |=> (pc_q == $past(pc_q) + 32'd1));

  assert_beq_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && opc == 3'b100) |=>
      (pc_q == ($past(alu_eq) ? $past(pc_q) + 32'd1 + $past(off_ext) : $past(pc_q) + 32'd1)));

  assert_no_rf_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == 3'b011 || opc == 3'b100 || opc == 3'b110 || opc == 3'b111) |-> !rf_we);

  assert_store_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we |-> (run_i && opc == 3'b011));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q));
endmodule

bind sc_proc sc_proc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .opc     (opc),
  .pc_q    (pc_q),
  .rd_a    (rd_a),
  .off_ext (off_ext),
  .alu_eq  (alu_eq),
  .rf_we   (rf_we),
  .dmem_we (dmem_we)
);

// File: tb/tb_sc_proc.sv
`timescale 1ns/1ps
module tb_sc_proc;
  localparam int ID = 64;
  localparam int DD = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run = 1'b0;
  logic        iwe = 1'b0, dwe = 1'b0;
  logic [5:0]  iaddr = '0, daddr = '0, paddr = '0;
  logic [24:0] idata = '0;
  logic [31:0] ddata = '0;
  logic [2:0]  psel = '0;
  logic [31:0] preg, pmem, pc;
  logic        halt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_reg [8];
  logic [31:0] m_mem [DD];
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  sc_proc #(.IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run),
    .imem_ld_we_i(iwe), .imem_ld_addr_i(iaddr), .imem_ld_data_i(idata),
    .dmem_ld_we_i(dwe), .dmem_ld_addr_i(daddr), .dmem_ld_data_i(ddata),
    .peek_reg_sel_i(psel), .peek_reg_o(preg),
    .peek_mem_addr_i(paddr), .peek_mem_o(pmem),
    .pc_o(pc), .halt_o(halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare_state(input string tag);
    for (int i = 0; i < 8; i++) begin
      psel = i[2:0];
      #1;
      chk($sformatf("%s reg%0d", tag, i), preg, m_reg[i]);
    end
    chk({tag, " pc"}, pc, m_pc);
  endtask

  task automatic check_mem(input string tag, input logic [5:0] a);
    paddr = a;
    #1;
    chk($sformatf("%s mem[%0d]", tag, a), pmem, m_mem[a]);
  endtask

  function automatic logic [24:0] enc_r(input logic [2:0] op, input int a, input int b, input int d);
    return {op, a[2:0], b[2:0], 13'd0, d[2:0]};
  endfunction

  function automatic logic [24:0] enc_i(input logic [2:0] op, input int a, input int b, input logic [15:0] off);
    return {op, a[2:0], b[2:0], off};
  endfunction

  // instruction-level reference model
  task automatic model(input logic [24:0] ins, output logic [5:0] maddr);
    logic [2:0]  op, a, b, d;
    logic [31:0] off, t, ea;
    op = ins[24:22]; a = ins[21:19]; b = ins[18:16]; d = ins[2:0];
    off = {{16{ins[15]}}, ins[15:0]};
    ea = m_reg[a] + off;
    maddr = ea[5:0];
    case (op)
      3'b000: begin m_reg[d] = m_reg[a] + m_reg[b]; m_pc = m_pc + 1; end
      3'b001: begin m_reg[d] = ~(m_reg[a] & m_reg[b]); m_pc = m_pc + 1; end
      3'b010: begin m_reg[b] = m_mem[ea[5:0]]; m_pc = m_pc + 1; end
      3'b011: begin m_mem[ea[5:0]] = m_reg[b]; m_pc = m_pc + 1; end
      3'b100: m_pc = (m_reg[a] == m_reg[b]) ? m_pc + 1 + off : m_pc + 1;
      3'b101: begin t = m_reg[a]; m_reg[b] = m_pc + 1; m_pc = t; end
      3'b110: ;
      default: m_pc = m_pc + 1;
    endcase
  endtask

  task automatic load_instr(input logic [24:0] ins);
    @(negedge clk);
    iwe = 1'b1; iaddr = m_pc[5:0]; idata = ins;
    @(negedge clk);
    iwe = 1'b0;
  endtask

  task automatic step(input logic [24:0] ins, input string tag);
    logic [5:0] ma;
    load_instr(ins);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    model(ins, ma);
    compare_state(tag);
    if (ins[24:22] == 3'b011) check_mem(tag, ma);
    if (ins[24:22] == 3'b110) begin checks++; if (halt !== 1'b1) begin errors++;
      $display("FAIL %s halt_o act=%b exp=1", tag, halt); end end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_pc = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    compare_state("R1 reset");

    // R10: data-store loading while idle
    for (int i = 0; i < DD; i++) begin
      @(negedge clk);
      dwe = 1'b1; daddr = i[5:0];
      ddata = 32'h9E3779B9 * (i + 1);
      if (i == 5) ddata = 32'h8000_0000;
      if (i == 6) ddata = 32'hFFFF_FFFF;
      if (i == 7) ddata = 32'h7FFF_FFFF;
      m_mem[i] = ddata;
    end
    @(negedge clk);
    dwe = 1'b0;
    for (int i = 0; i < 8; i++) check_mem("R10 load", i[5:0]);

    // R4: fill registers via load, r0 last while it is still zero
    for (int i = 7; i >= 0; i--) step(enc_i(3'b010, 0, i, 16'(i)), "R4 lw fill");
    // R4: negative offset wrapping
    step(enc_i(3'b010, 1, 2, 16'hFFFF), "R4 lw negoff");

    // R2 / R3: all register pairs
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        step(enc_r(3'b000, a, b, (a + b) % 8), "R2 add");
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        step(enc_r(3'b001, a, b, (a + 3 * b) % 8), "R3 nand");

    // R5 / R4: stores then loads through all pairs
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        step(enc_i(3'b011, a, b, 16'(a * 8 + b - 20)), "R5 sw");
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        step(enc_i(3'b010, a, b, 16'(b * 5 - a)), "R4 lw");

    // R6: taken (same register), negative offset, then all pairs
    step(enc_i(3'b100, 3, 3, 16'd5), "R6 beq taken");
    step(enc_i(3'b100, 4, 4, 16'hFFFD), "R6 beq back");
    step(enc_r(3'b000, 2, 2, 6), "R6 setup");
    step(enc_i(3'b100, 2, 6, 16'd9), "R6 beq not taken");
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        step(enc_i(3'b100, a, b, 16'(a - b)), "R6 beq");

    // R7: jalr on all pairs, including a==b
    step(enc_i(3'b101, 5, 5, 16'd0), "R7 jalr same");
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        step(enc_i(3'b101, a, b, 16'd0), "R7 jalr");

    // R8: halt holds PC over repeated cycles
    step(enc_i(3'b110, 1, 2, 16'd7), "R8 halt");
    run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    compare_state("R8 halt hold");
    // R9: no-op
    step(enc_i(3'b111, 1, 1, 16'h1234), "R9 nop");
    step(enc_i(3'b111, 7, 0, 16'hFFFF), "R9 nop2");

    // R10: idle cycles with a pending add change nothing
    load_instr(enc_r(3'b000, 1, 2, 3));
    repeat (5) @(negedge clk);
    compare_state("R10 idle");
    step(enc_r(3'b000, 1, 2, 3), "R10 after idle");

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_pc = '0;
    compare_state("R1 mid reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule